// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block sits beside a small CPU core and decides which of five interrupt sources the core services next. The sources are a non-maskable trap, three restart inputs ranked 7.5, 6.5 and 5.5, and one general request. The trap and the three restarts make the core jump to a fixed restart address, which the controller supplies. The general request instead stops the program counter from advancing and raises an acknowledge strobe, so that external hardware can place an instruction on the bus.

The core pulses `sample_slot` in the next-to-last clock of every instruction. Only at that edge does the controller look at its pending sources. If a source wins, the controller reports it on the following cycle and clears the global enable.

Software state has three parts. The global enable is set and cleared by dedicated strobes. Three mask bits and a latch-clear bit are written together in one mask-set operation. The 7.5 input is captured by an edge latch. The trap needs a rising edge, and its level must still be high when it is sampled.

Top module: `restart_irq_ctrl`

## Requirements
- R1: After synchronous reset, `int_en` is 0, `take_valid`, `ack_strobe` and `pc_hold` are 0, all three restart mask bits are set (masked), and both edge latches are empty.
- R2: When several sources are pending at a sampling edge, the winner follows a fixed order, highest first: trap, 7.5, 6.5, 5.5, general request. `take_src` encodes the winner as 1 for trap, 2 for 7.5, 3 for 6.5, 4 for 5.5 and 5 for the general request (0 = none).
- R3: A rising edge on `rst75_in` is remembered even after the input falls. Once that edge is accepted, holding the input high raises no further request.
- R4: The 6.5 and 5.5 inputs are level sensitive: they are considered only if high at the sampling edge, and they leave no memory behind.
- R5: The trap is taken only if a rising edge on `trap_in` was seen and the input is still high at the sampling edge. It ignores `int_en` and every mask bit. An accepted trap needs a new rising edge before it can be taken again.
- R6: A mask-set write (`mask_wr`) loads `mask_data[0]` as the 5.5 mask, `[1]` as the 6.5 mask and `[2]` as the 7.5 mask, where 1 blocks the source. `mask_data[3]=1` empties the 7.5 edge latch. The three restarts and the general request are taken only while `int_en` is 1.
- R7: Sources are sampled only at a clock edge where `sample_slot` is 1. The result appears on `take_valid`/`take_src` in the cycle that follows; otherwise `take_valid` is 0.
- R8: `int_en` is set by `ien_set` and cleared by `ien_clr`; clear wins if both are high. Any acceptance clears it at that same edge, overriding `ien_set`.
- R9: For trap, 7.5, 6.5 and 5.5, `vec_insert` is 1 together with `take_valid`. `vec_addr` is then 0x24, 0x3C, 0x34 and 0x2C respectively, and no acknowledge strobe is raised. Without a restart acceptance, `vec_addr` is 0.
- R10: An accepted general request gives `vec_insert`=0, a one-cycle `pc_hold` together with `take_valid`, and `ack_strobe` high for ACK_LEN cycles (default 2) starting in that cycle.
- R11: Acceptance of the 7.5 request empties its edge latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_in | input | 1 | Non-maskable trap request |
| rst75_in | input | 1 | Edge-triggered restart 7.5 request |
| rst65_in | input | 1 | Level-triggered restart 6.5 request |
| rst55_in | input | 1 | Level-triggered restart 5.5 request |
| gen_req_in | input | 1 | General interrupt request |
| sample_slot | input | 1 | Core is in the next-to-last clock of an instruction |
| mask_wr | input | 1 | Mask-set write strobe |
| mask_data | input | 4 | Mask bits [2:0], latch-clear bit [3] |
| ien_set | input | 1 | Set global enable |
| ien_clr | input | 1 | Clear global enable |
| take_valid | output | 1 | An interrupt was accepted at the previous edge |
| take_src | output | 3 | Encoded winning source |
| vec_insert | output | 1 | Core must insert a restart to `vec_addr` |
| vec_addr | output | VEC_W | Fixed restart address of the winner |
| pc_hold | output | 1 | Inhibit the program counter increment |
| ack_strobe | output | 1 | Acknowledge strobe for the general request |
| int_en | output | 1 | Global interrupt enable state |

## Verification
On every cycle, the assertions check these properties:
- An acceptance follows only a sampling slot.
- An acceptance always clears the enable.
- Maskable winners require the enable that was in force before the edge.
- A winning trap had its level high.
- Restart winners insert a vector and never acknowledge.
- General winners hold the program counter and acknowledge.

Only the bench scenarios can show the rest: the priority order among simultaneous sources, that a 7.5 edge is kept after its input drops, that a held trap or 7.5 level does not fire again, and that mask writes and the latch-clear bit take effect. The random phase compares every output each cycle against a bench model built from the requirements.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int N_RESTART = 3;
  localparam int SRC_W     = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_GEN  = 3'd5
  } irq_src_e;

  function automatic logic [7:0] src_vector(irq_src_e s);
    case (s)
      SRC_TRAP: src_vector = 8'h24;
      SRC_R75:  src_vector = 8'h3C;
      SRC_R65:  src_vector = 8'h34;
      SRC_R55:  src_vector = 8'h2C;
      default:  src_vector = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter bit LEVEL_QUAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic clr,
  output logic pend
);

  logic din_d;
  logic lat_q;
  logic lat_n;
  logic rise;

  assign rise = din & ~din_d;

  generate
    if (LEVEL_QUAL) begin : g_level
      // edge arms the latch, a low level cancels it
      assign lat_n = din & ((lat_q & ~clr) | rise);
      assign pend  = lat_q & din;
    end else begin : g_edge
      assign lat_n = (lat_q | rise) & ~clr;
      assign pend  = lat_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      din_d <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      din_d <= din;
      lat_q <= lat_n;
    end
  end

endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
  import irq_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mask_wr,
  input  logic [N_RESTART:0]   mask_data,
  input  logic                 ien_set,
  input  logic                 ien_clr,
  input  logic                 accept,
  output logic [N_RESTART-1:0] mask_q,
  output logic                 ien_q,
  output logic                 clr_edge
);

  assign clr_edge = mask_wr & mask_data[N_RESTART];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      ien_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_data[N_RESTART-1:0];
      if (accept)       ien_q <= 1'b0;
      else if (ien_clr) ien_q <= 1'b0;
      else if (ien_set) ien_q <= 1'b1;
    end
  end

  AST_ACCEPT_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ien_q); // R8

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_ctrl_pkg::*;
(
  input  logic                 trap_p,
  input  logic [N_RESTART-1:0] rst_p,   // [2]=7.5 [1]=6.5 [0]=5.5
  input  logic                 gen_p,
  output irq_src_e             win
);

  always_comb begin
    win = SRC_NONE;
    if (gen_p) win = SRC_GEN;
    for (int i = 0; i < N_RESTART; i++) begin
      if (rst_p[i]) win = irq_src_e'(SRC_R55 - i[SRC_W-1:0]);
    end
    if (trap_p) win = SRC_TRAP;
  end

endmodule

// File: rtl/irq_ack_timer.sv
module irq_ack_timer #(
  parameter int ACK_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ack
);

  localparam int CNT_W = $clog2(ACK_LEN + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (start)       cnt_q <= CNT_W'(ACK_LEN);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign ack = (cnt_q != '0);

  AST_ACK_STARTS: assert property (@(posedge clk) disable iff (rst)
    start |=> ack); // R10

endmodule

// File: rtl/restart_irq_ctrl.sv
module restart_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int ACK_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trap_in,
  input  logic             rst75_in,
  input  logic             rst65_in,
  input  logic             rst55_in,
  input  logic             gen_req_in,
  input  logic             sample_slot,
  input  logic             mask_wr,
  input  logic [3:0]       mask_data,
  input  logic             ien_set,
  input  logic             ien_clr,
  output logic             take_valid,
  output logic [2:0]       take_src,
  output logic             vec_insert,
  output logic [VEC_W-1:0] vec_addr,
  output logic             pc_hold,
  output logic             ack_strobe,
  output logic             int_en
);

  logic [N_RESTART-1:0] mask_q;
  logic                 ien_q;
  logic                 clr_edge;
  logic                 trap_pend;
  logic                 r75_pend;
  logic [N_RESTART-1:0] rst_raw;
  logic [N_RESTART-1:0] rst_p;
  logic                 gen_p;
  irq_src_e             pick;
  irq_src_e             win;
  logic                 accept;

  logic                 valid_q;
  irq_src_e             src_q;
  logic                 ins_q;
  logic [VEC_W-1:0]     vec_q;
  logic                 hold_q;

  irq_enable_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .mask_wr   (mask_wr),
    .mask_data (mask_data),
    .ien_set   (ien_set),
    .ien_clr   (ien_clr),
    .accept    (accept),
    .mask_q    (mask_q),
    .ien_q     (ien_q),
    .clr_edge  (clr_edge)
  );

  irq_edge_latch #(.LEVEL_QUAL(1'b1)) u_trap (
    .clk  (clk),
    .rst  (rst),
    .din  (trap_in),
    .clr  (win == SRC_TRAP),
    .pend (trap_pend)
  );

  irq_edge_latch #(.LEVEL_QUAL(1'b0)) u_r75 (
    .clk  (clk),
    .rst  (rst),
    .din  (rst75_in),
    .clr  ((win == SRC_R75) | clr_edge),
    .pend (r75_pend)
  );

  assign rst_raw = {r75_pend, rst65_in, rst55_in};
  assign rst_p   = rst_raw & ~mask_q & {N_RESTART{ien_q}};
  assign gen_p   = gen_req_in & ien_q;

  irq_prio_pick u_pick (
    .trap_p (trap_pend),
    .rst_p  (rst_p),
    .gen_p  (gen_p),
    .win    (pick)
  );

  assign win    = sample_slot ? pick : SRC_NONE;
  assign accept = (win != SRC_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      src_q   <= SRC_NONE;
      ins_q   <= 1'b0;
      vec_q   <= '0;
      hold_q  <= 1'b0;
    end else begin
      valid_q <= accept;
      src_q   <= win;
      ins_q   <= accept && (win != SRC_GEN);
      vec_q   <= VEC_W'(src_vector(win));
      hold_q  <= (win == SRC_GEN);
    end
  end

  irq_ack_timer #(.ACK_LEN(ACK_LEN)) u_ack (
    .clk   (clk),
    .rst   (rst),
    .start (win == SRC_GEN),
    .ack   (ack_strobe)
  );

  assign take_valid = valid_q;
  assign take_src   = src_q;
  assign vec_insert = ins_q;
  assign vec_addr   = vec_q;
  assign pc_hold    = hold_q;
  assign int_en     = ien_q;

  AST_TAKE_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
    take_valid |-> $past(sample_slot)); // R7
  AST_TAKE_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
    take_valid |-> !int_en); // R8
  AST_MASKABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (take_valid && take_src != 3'd1) |-> $past(int_en)); // R6
  AST_TRAP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (take_valid && take_src == 3'd1) |-> $past(trap_in)); // R5
  AST_RESTART_VEC: assert property (@(posedge clk) disable iff (rst)
    (take_valid && take_src != 3'd5) |-> (vec_insert && !pc_hold)); // R9
  AST_GEN_ACK: assert property (@(posedge clk) disable iff (rst)
    (take_valid && take_src == 3'd5) |-> (ack_strobe && pc_hold && !vec_insert)); // R10

endmodule

// File: tb/restart_irq_ctrl_tb.sv
module restart_irq_ctrl_tb;

  localparam int ACK_LEN = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_in = 0, rst75_in = 0, rst65_in = 0, rst55_in = 0, gen_req_in = 0;
  logic sample_slot = 0, mask_wr = 0, ien_set = 0, ien_clr = 0;
  logic [3:0] mask_data = 4'h0;
  logic       take_valid, vec_insert, pc_hold, ack_strobe, int_en;
  logic [2:0] take_src;
  logic [7:0] vec_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model state
  logic       m_ien, m_l75, m_ltrap, m_trap_d, m_r75_d;
  logic [2:0] m_mask;
  int         m_ack_cnt;
  logic       e_valid, e_ins, e_hold;
  logic [2:0] e_src;
  logic [7:0] e_vec;

  always #5 clk = ~clk;

  restart_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .trap_in(trap_in), .rst75_in(rst75_in),
    .rst65_in(rst65_in), .rst55_in(rst55_in), .gen_req_in(gen_req_in),
    .sample_slot(sample_slot), .mask_wr(mask_wr), .mask_data(mask_data),
    .ien_set(ien_set), .ien_clr(ien_clr), .take_valid(take_valid),
    .take_src(take_src), .vec_insert(vec_insert), .vec_addr(vec_addr),
    .pc_hold(pc_hold), .ack_strobe(ack_strobe), .int_en(int_en)
  );

  function automatic logic [7:0] exp_vec(logic [2:0] s);
    case (s)
      3'd1: return 8'h24;
      3'd2: return 8'h3C;
      3'd3: return 8'h34;
      3'd4: return 8'h2C;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ien = 0; m_l75 = 0; m_ltrap = 0; m_trap_d = 0; m_r75_d = 0;
    m_mask = 3'b111; m_ack_cnt = 0;
    e_valid = 0; e_src = 0; e_ins = 0; e_vec = 0; e_hold = 0;
  endtask

  // expected state after the coming clock edge, from the current inputs
  task automatic model_step();
    logic rise_t, rise75, tp, p75, p65, p55, pg;
    logic [2:0] w;
    rise_t = trap_in & ~m_trap_d;
    rise75 = rst75_in & ~m_r75_d;
    tp  = m_ltrap & trap_in;
    p75 = m_l75 & ~m_mask[2] & m_ien;
    p65 = rst65_in & ~m_mask[1] & m_ien;
    p55 = rst55_in & ~m_mask[0] & m_ien;
    pg  = gen_req_in & m_ien;
    w = 3'd0;
    if (sample_slot) begin
      if (tp) w = 3'd1;
      else if (p75) w = 3'd2;
      else if (p65) w = 3'd3;
      else if (p55) w = 3'd4;
      else if (pg)  w = 3'd5;
    end
    if (w != 0) m_ien = 0;
    else if (ien_clr) m_ien = 0;
    else if (ien_set) m_ien = 1;
    m_l75   = (m_l75 | rise75) & ~(w == 3'd2) & ~(mask_wr & mask_data[3]);
    m_ltrap = trap_in & ((m_ltrap & (w != 3'd1)) | rise_t);
    if (mask_wr) m_mask = mask_data[2:0];
    m_trap_d = trap_in;
    m_r75_d  = rst75_in;
    if (w == 3'd5) m_ack_cnt = ACK_LEN;
    else if (m_ack_cnt > 0) m_ack_cnt--;
    e_valid = (w != 0);
    e_src   = w;
    e_ins   = (w != 0) && (w != 3'd5);
    e_vec   = exp_vec(w);
    e_hold  = (w == 3'd5);
  endtask

  // inputs were set at a falling edge; run one clock and compare at the next
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(take_valid, e_valid, "R7 take_valid");
    chk(take_src, e_src, "R2 take_src");
    chk(vec_insert, e_ins, "R9 vec_insert");
    chk(vec_addr, e_vec, "R9 vec_addr");
    chk(pc_hold, e_hold, "R10 pc_hold");
    chk(ack_strobe, m_ack_cnt > 0, "R10 ack_strobe");
    chk(int_en, m_ien, "R8 int_en");
  endtask

  task automatic idle();
    sample_slot = 0; mask_wr = 0; ien_set = 0; ien_clr = 0; mask_data = 0;
  endtask

  task automatic enable_and_sample();
    idle(); ien_set = 1; cyc();
    idle(); sample_slot = 1; cyc();
    idle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(int_en, 0, "R1 int_en");
    chk(take_valid, 0, "R1 take_valid");
    chk(ack_strobe, 0, "R1 ack_strobe");
    chk(pc_hold, 0, "R1 pc_hold");
    // R1/R6: masks set after reset block 6.5 even when enabled
    rst65_in = 1;
    enable_and_sample();
    chk(take_valid, 0, "R1 masks set after reset");
    rst65_in = 0;
    // R6: unmask all
    mask_wr = 1; mask_data = 4'b0000; cyc(); idle();
    // R2: all sources at once
    trap_in = 1; rst75_in = 1; rst65_in = 1; rst55_in = 1; gen_req_in = 1;
    cyc();
    enable_and_sample();
    chk(take_src, 1, "R2 trap wins");
    chk(vec_addr, 8'h24, "R9 trap vector");
    // R5: trap held high, no new edge: next winner is 7.5
    enable_and_sample();
    chk(take_src, 2, "R2 7.5 second");
    chk(vec_addr, 8'h3C, "R9 7.5 vector");
    // R11/R3: 7.5 held high does not refire
    enable_and_sample();
    chk(take_src, 3, "R11 7.5 latch emptied, 6.5 next");
    rst65_in = 0;
    enable_and_sample();
    chk(take_src, 4, "R2 5.5 next");
    rst55_in = 0;
    enable_and_sample();
    chk(take_src, 5, "R10 general taken");
    chk(ack_strobe, 1, "R10 ack high");
    chk(vec_insert, 0, "R10 no vector");
    trap_in = 0; rst75_in = 0; gen_req_in = 0;
    // R7: no sample slot, no acceptance
    idle(); ien_set = 1; rst65_in = 1; cyc(); idle();
    repeat (4) begin
      cyc();
      chk(take_valid, 0, "R7 no slot no take");
    end
    // R4: level dropped before sample is forgotten
    rst65_in = 0; sample_slot = 1; cyc(); idle();
    chk(take_valid, 0, "R4 level gone");
    // R3: short 7.5 pulse is remembered
    rst75_in = 1; cyc(); rst75_in = 0; cyc(); cyc();
    sample_slot = 1; cyc(); idle();
    chk(take_src, 2, "R3 pulse remembered");
    // R6: latch-clear bit empties a pending 7.5 edge
    rst75_in = 1; cyc(); rst75_in = 0;
    mask_wr = 1; mask_data = 4'b1000; cyc(); idle();
    enable_and_sample();
    chk(take_valid, 0, "R6 latch cleared by mask write");
    // R5: trap with enable off and all masked
    mask_wr = 1; mask_data = 4'b0111; ien_clr = 1; cyc(); idle();
    trap_in = 1; cyc();
    sample_slot = 1; cyc(); idle();
    chk(take_src, 1, "R5 trap ignores masks and enable");
    // R5: trap pulse that dropped before sampling is not taken
    trap_in = 0; cyc(); trap_in = 1; cyc(); trap_in = 0;
    sample_slot = 1; cyc(); idle();
    chk(take_valid, 0, "R5 trap needs level");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(7) == 0) trap_in = ~trap_in;
      if ($urandom_range(5) == 0) rst75_in = ~rst75_in;
      if ($urandom_range(5) == 0) rst65_in = ~rst65_in;
      if ($urandom_range(5) == 0) rst55_in = ~rst55_in;
      if ($urandom_range(4) == 0) gen_req_in = ~gen_req_in;
      sample_slot = ($urandom_range(2) == 0);
      ien_set     = ($urandom_range(3) == 0);
      ien_clr     = ($urandom_range(15) == 0);
      mask_wr     = ($urandom_range(9) == 0);
      mask_data   = 4'($urandom_range(15));
      cyc();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule